// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen architectural general registers of a processor core. Some of their storage is swapped according to the current operating mode. A 3-bit mode input chooses which physical copy a banked index reaches. The lower eight registers are common to all modes. The fast-interrupt mode keeps private copies of indices 8 through 14. Each of the other exception modes keeps private copies of only indices 13 (stack pointer) and 14 (link register), and shares indices 8 through 12 with user mode.

The block has two combinational read ports and one write port. The write port updates storage on the rising clock edge. All three ports take a 4-bit architectural index. Index 15 is the program counter, which lives elsewhere. Reading it returns zero, and writing it does nothing. The core drives the mode together with each access, so a write always lands in the bank that the mode selects in that same cycle.

Top module: `mode_banked_rf`

## Requirements
- R1: The active-low reset clears every physical entry, so after reset every index in every mode reads zero.
- R2: Indices 0 to 7 reach the same storage in all eight mode codes. A write made in any mode is visible to a read made in any other mode.
- R3: Mode codes 0 (user), 2 (interrupt), 3 (supervisor), 4 (abort) and 5 (undefined) share one copy of indices 8 to 12. Codes 6 and 7 behave exactly like code 0 for every index.
- R4: Mode code 1 (fast interrupt) has its own copies of indices 8 to 14. No other mode can read or change these copies.
- R5: Each of mode codes 2, 3, 4 and 5 has its own copies of indices 13 and 14. These copies are separate from each other, from the fast-interrupt copies and from the user copy.
- R6: A read of index 15 returns zero on both ports, and a write to index 15 changes no entry.
- R7: A write takes its bank from the mode present in the cycle in which the write enable is high. The written value can be read in the next cycle.
- R8: Reads are combinational. A read of the entry being written in the same cycle returns the value held before the write.
- R9: The two read ports are independent. Each one returns the entry for its own index under the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operating mode code |
| ra_addr_i | input | 4 | Read port A architectural index |
| ra_data_o | output | DATA_W | Read port A data |
| rb_addr_i | input | 4 | Read port B architectural index |
| rb_data_o | output | DATA_W | Read port B data |
| we_i | input | 1 | Write enable |
| wr_addr_i | input | 4 | Write architectural index |
| wr_data_i | input | DATA_W | Write data |

## Verification
The bench writes a unique value to every index in all eight mode codes and then reads the whole matrix back on both ports. This catches a mapping that aliases two banks, such as an interrupt-mode stack pointer that overwrites the supervisor copy, or a fast-interrupt register that leaks into user mode. It also catches the unused codes 6 and 7 being routed to a private bank instead of the user bank. Targeted cycles cover two more timing cases. In one, the mode changes in the same cycle as a write; a design that registered the mode would fill the previous bank. In the other, a port reads the entry being written; a design with write-through forwarding would return the new value one cycle early. Writes to index 15 followed by a full sweep expose a design that stores the program counter index in some entry or returns nonzero for it.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;
  localparam int ARCH_N    = 16;
  localparam int IDX_W     = $clog2(ARCH_N);
  localparam int MODE_W    = 3;
  localparam int BANK_LO   = 8;                 // first banked index
  localparam int SP_IDX    = 13;                // first per-exception index
  localparam int PC_IDX    = ARCH_N - 1;        // not stored
  localparam int EXC_SLOTS = PC_IDX - SP_IDX;   // sp + lr
  localparam int N_EXC_STD = 4;                 // irq, svc, abt, und
  localparam int FIQ_BASE  = PC_IDX;            // after shared + user banked
  localparam int EXC_BASE  = FIQ_BASE + (PC_IDX - BANK_LO);
  localparam int PHYS_N    = EXC_BASE + N_EXC_STD * EXC_SLOTS;
  localparam int PHYS_W    = $clog2(PHYS_N);

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 3'd0,
    MODE_FIQ = 3'd1,
    MODE_IRQ = 3'd2,
    MODE_SVC = 3'd3,
    MODE_ABT = 3'd4,
    MODE_UND = 3'd5
  } mode_e;
endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
  import mbrf_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [PHYS_W-1:0] phys_o,
  output logic              valid_o
);
  int i;
  int p;

  always_comb begin
    i       = int'(idx_i);
    p       = i;
    valid_o = (i != PC_IDX);
    if (i == PC_IDX) begin
      p = 0;
    end else if (i >= BANK_LO) begin
      case (mode_e'(mode_i))
        MODE_FIQ: p = FIQ_BASE + i - BANK_LO;
        MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND: begin
          if (i >= SP_IDX)
            p = EXC_BASE + (int'(mode_i) - int'(MODE_IRQ)) * EXC_SLOTS + i - SP_IDX;
        end
        default: p = i;  // user and unused codes
      endcase
    end
    phys_o = PHYS_W'(p);
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [PHYS_W-1:0]        waddr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [PHYS_N*DATA_W-1:0] q_o
);
  for (genvar e = 0; e < PHYS_N; e++) begin : g_cell
    logic              sel;
    logic [DATA_W-1:0] cell_q;

    assign sel = we_i && (waddr_i == PHYS_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cell_q <= '0;
      else if (sel) cell_q <= wdata_i;
    end

    assign q_o[e*DATA_W +: DATA_W] = cell_q;
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [PHYS_N*DATA_W-1:0] q_i,
  input  logic [PHYS_W-1:0]        phys_i,
  input  logic                     valid_i,
  output logic [DATA_W-1:0]        data_o
);
  always_comb begin
    data_o = '0;
    if (valid_i) data_o = q_i[int'(phys_i)*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/mode_banked_rf.sv
module mode_banked_rf
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic [3:0]        ra_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [3:0]        rb_addr_i,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              we_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int NRP = 2;

  logic [PHYS_N*DATA_W-1:0] store_q;
  logic [PHYS_W-1:0]        w_phys;
  logic                     w_ok;
  logic [IDX_W-1:0]         rd_idx [NRP];
  logic [DATA_W-1:0]        rd_dat [NRP];

  rf_bank_map u_wmap (
    .mode_i  (mode_i),
    .idx_i   (wr_addr_i),
    .phys_o  (w_phys),
    .valid_o (w_ok)
  );

  rf_storage #(.DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i & w_ok),
    .waddr_i (w_phys),
    .wdata_i (wr_data_i),
    .q_o     (store_q)
  );

  assign rd_idx[0] = ra_addr_i;
  assign rd_idx[1] = rb_addr_i;

  for (genvar g = 0; g < NRP; g++) begin : g_rd
    logic [PHYS_W-1:0] phys;
    logic              ok;

    rf_bank_map u_map (
      .mode_i  (mode_i),
      .idx_i   (rd_idx[g]),
      .phys_o  (phys),
      .valid_o (ok)
    );

    rf_read_port #(.DATA_W(DATA_W)) u_port (
      .q_i     (store_q),
      .phys_i  (phys),
      .valid_i (ok),
      .data_o  (rd_dat[g])
    );
  end

  assign ra_data_o = rd_dat[0];
  assign rb_data_o = rd_dat[1];
endmodule

// File: rtl/mbrf_checker.sv
module mbrf_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        mode_i,
  input logic [3:0]        ra_addr_i,
  input logic [DATA_W-1:0] ra_data_o,
  input logic [3:0]        rb_addr_i,
  input logic [DATA_W-1:0] rb_data_o,
  input logic              we_i,
  input logic [3:0]        wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (ra_data_o == '0 && rb_data_o == '0));

  p_shared_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && $past(wr_addr_i) < 4'd8 && ra_addr_i == $past(wr_addr_i))
    |-> ra_data_o == $past(wr_data_i));

  p_pc_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_addr_i == 4'd15) |-> ra_data_o == '0);

  p_pc_zero_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_addr_i == 4'd15) |-> rb_data_o == '0);

  p_same_bank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && $past(wr_addr_i) != 4'd15 && mode_i == $past(mode_i) &&
     ra_addr_i == $past(wr_addr_i))
    |-> ra_data_o == $past(wr_data_i));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(we_i) && $stable(ra_addr_i) && $stable(mode_i)) |-> $stable(ra_data_o));
endmodule

bind mode_banked_rf mbrf_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_mode_banked_rf.sv
module sim_mode_banked_rf;
  localparam int W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [2:0]   mode_i;
  logic [3:0]   ra_addr_i, rb_addr_i, wr_addr_i;
  logic         we_i;
  logic [W-1:0] wr_data_i, ra_data_o, rb_data_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [W-1:0] model [6][15];

  always #4 clk_i = ~clk_i;  // 125 MHz

  mode_banked_rf #(.DATA_W(W)) u0 (.*);

  // bank 0 = user copy, 1 = fast interrupt, 2..5 = per-exception sp/lr
  function automatic int bank_of(int m, int i);
    if (i < 8) return 0;
    if (m == 1) return 1;
    if (i >= 13 && m >= 2 && m <= 5) return m;
    return 0;
  endfunction

  function automatic logic [W-1:0] exp_of(int m, int i);
    if (i == 15) return '0;
    return model[bank_of(m, i)][i];
  endfunction

  function automatic string tag(int m, int i);
    if (i == 15) return "R6";
    if (i < 8) return "R2";
    if (m == 1) return "R4";
    if (i >= 13 && m >= 2 && m <= 5) return "R5";
    return "R3";
  endfunction

  task automatic chk(string r, logic [W-1:0] got, logic [W-1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", r, got, exp);
    end
  endtask

  task automatic clear_model();
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 15; i++) model[b][i] = '0;
  endtask

  task automatic rd(string pfx, int m, int a, int b);
    @(negedge clk_i);
    we_i = 1'b0; mode_i = 3'(m); ra_addr_i = 4'(a); rb_addr_i = 4'(b);
    #1;
    chk({pfx, tag(m, a), " A"}, ra_data_o, exp_of(m, a));
    chk({pfx, "R9/", tag(m, b), " B"}, rb_data_o, exp_of(m, b));
  endtask

  task automatic wr(int m, int i, logic [W-1:0] d);
    @(negedge clk_i);
    mode_i = 3'(m); wr_addr_i = 4'(i); wr_data_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    if (i != 15) model[bank_of(m, i)][i] = d;
  endtask

  task automatic sweep(string pfx);
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 16; i++) rd(pfx, m, i, 15 - i);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; we_i = 1'b0; mode_i = '0;
    ra_addr_i = '0; rb_addr_i = '0; wr_addr_i = '0; wr_data_i = '0;
    clear_model();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    sweep("R1/");  // all zero after reset

    // unique value per (mode, index); later modes overwrite shared entries
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 16; i++)
        wr(m, i, 32'hC000_0000 | W'(m << 8) | W'(i << 4) | 32'h1);
    sweep("");

    // R8: a read of the entry being written sees the old value
    @(negedge clk_i);
    mode_i = 3'd3; wr_addr_i = 4'd13; wr_data_i = 32'h5A5A_0001; we_i = 1'b1;
    ra_addr_i = 4'd13; rb_addr_i = 4'd13;
    #1;
    chk("R8 same-cycle A", ra_data_o, model[3][13]);
    chk("R8 same-cycle B", rb_data_o, model[3][13]);
    @(negedge clk_i);
    we_i = 1'b0;
    model[3][13] = 32'h5A5A_0001;
    #1;
    chk("R7 next-cycle", ra_data_o, model[3][13]);

    // R7: mode switches in the same cycle as the write
    @(negedge clk_i);
    mode_i = 3'd4; wr_addr_i = 4'd14; wr_data_i = 32'h0BAD_0004; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    model[4][14] = 32'h0BAD_0004;
    rd("R7/", 3, 14, 14);
    rd("R7/", 4, 14, 13);
    wr(1, 9, 32'h0F10_0009);
    rd("R7/", 0, 9, 9);
    rd("R7/", 1, 9, 9);

    // R6: writes to index 15 in every mode change nothing
    for (int m = 0; m < 8; m++) wr(m, 15, 32'hFFFF_FFFF);
    sweep("R6/");

    // R1: reset in mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    clear_model();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    sweep("R1/");

    summary();
    $finish;
  end
endmodule